// File: doc/BRIEF.md
# Serial Port with Two-Part Baud Divisor

This block is an asynchronous serial port attached to a small word-wide register bus. The CPU feeds transmit bytes and collects received bytes through a single data register: a write pushes a byte into a 32-entry transmit queue, and a read pops the oldest byte from a 32-entry receive queue. A status register reports an empty receive queue, a full transmit queue and a sticky overrun condition. The serial line uses 8N1 framing: one low start bit, eight data bits sent least significant bit first, and one high stop bit.

The bit period is a count of reference clock cycles, nominally the 96 MHz clock divided by the baud rate. Software does not write this count as one value. It writes the count shifted right by six into one register and the low six bits into another. The block joins the two halves and applies the result to every frame that starts after the write. The receiver synchronises its input and rejects a start pulse that has gone high again by the middle of the bit. It then samples each data bit at its midpoint.

Top module: `uart_split_div`

## Requirements
- R1: After reset, txd is high, the status register reads 0x10, and the two divisor registers read back the upper part (DEFAULT_DIV >> 6) and the lower part (DEFAULT_DIV & 63).
- R2: A write to offset 0x0 pushes reg_wdata[7:0] into the transmit queue. Each queued byte goes out on txd as a low start bit, eight data bits LSB first and a high stop bit. txd is high whenever no frame is being sent.
- R3: Every bit lasts D reference clock cycles, where D = hi*64 + lo. The upper part hi is written at offset 0x8 and the lower part lo at offset 0xC (bits 5:0 only). Both registers read back what was written.
- R4: A read of offset 0x0 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes that byte from the receive queue.
- R5: Each queue holds 32 bytes. A 33rd entry is never stored.
- R6: The status register at offset 0x4 has bit 4 = receive queue empty, bit 5 = transmit queue full, bit 0 = overrun. All other bits read 0.
- R7: A write to offset 0x0 while the transmit queue is full is dropped, and no byte is sent for it.
- R8: A complete frame that arrives while the receive queue is full is discarded and sets the overrun bit. The overrun bit stays set until reset.
- R9: A read of offset 0x0 while the receive queue is empty returns 0 and leaves the queue empty.
- R10: The receiver treats a low level as a start bit only if the line is still low half a bit period after the falling edge. A shorter low pulse receives no byte, and the next valid frame is still received correctly.
- R11: A divisor write during a frame does not change that frame's bit timing. The new divisor takes effect from the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 96 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Byte offset of the register being accessed |
| reg_wen | input | 1 | Write strobe, one transfer per clock |
| reg_ren | input | 1 | Read strobe; a read of the data offset pops a byte |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The hardest condition to reach is overrun. It needs 32 complete serial frames to land in the receive queue, followed by a 33rd, with no read in between. The bench therefore drives rxd directly with 33 back-to-back frames at a short divisor. It then checks the status word and drains the queue to confirm that exactly the first 32 bytes were kept.

A full transmit queue is just as hard to hold, because the shifter removes a byte as soon as one arrives. The bench reaches it by issuing 34 writes on consecutive clocks while the first frame is still on the wire. It then decodes every frame on txd to show that only the 34th byte went missing.

Loopback from txd to rxd exercises both directions together across several split-divisor settings.

// File: rtl/uart_split_pkg.sv
package uart_split_pkg;

   // register byte offsets on the 4-bit address
   localparam logic [3:0] OFS_DATA = 4'h0;
   localparam logic [3:0] OFS_STAT = 4'h4;
   localparam logic [3:0] OFS_DHI  = 4'h8;
   localparam logic [3:0] OFS_DLO  = 4'hC;

   // status bit positions
   localparam int ST_OVR = 0;
   localparam int ST_RXE = 4;
   localparam int ST_TXF = 5;

   // width of the lower divisor field
   localparam int LO_W = 6;

   typedef enum logic {
      TX_IDLE,
      TX_SEND
   } tx_state_e;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/usd_fifo.sv
module usd_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic [LVL_W-1:0] level
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("usd_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LVL_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr_q];

   // pointer wrap: free-running for a power of two, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr_q + 1'b1;
      assign rd_nxt = rd_ptr_q + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level    <= '0;
      end else begin
         if (do_push) begin
            wr_ptr_q <= wr_nxt;
         end
         if (do_pop) begin
            rd_ptr_q <= rd_nxt;
         end
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/usd_bit_timer.sv
module usd_bit_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] target,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   // expires on the target-th cycle after a restart edge
   assign expire = !restart && (cnt_q == target - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/usd_tx.sv
module usd_tx
   import uart_split_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             fifo_pop,
   output logic             txd,
   output logic             busy
);

   localparam int FRAME_W = 10;

   tx_state_e        st_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [3:0]       bitn_q;
   logic [DIV_W-1:0] div_q;
   logic             load, expire;

   assign load     = (st_q == TX_IDLE) && !fifo_empty;
   assign fifo_pop = load;
   assign txd      = shreg_q[0];
   assign busy     = (st_q == TX_SEND);

   usd_bit_timer #(.CNT_W(DIV_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .target  (div_q),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         shreg_q <= '1;
         bitn_q  <= '0;
         div_q   <= DIV_W'(2);
      end else if (load) begin
         // stop, data LSB first, start in bit 0
         shreg_q <= {1'b1, fifo_data, 1'b0};
         bitn_q  <= '0;
         div_q   <= div;
         st_q    <= TX_SEND;
      end else if (busy && expire) begin
         shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
         if (bitn_q == 4'(FRAME_W - 1)) begin
            st_q <= TX_IDLE;
         end else begin
            bitn_q <= bitn_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/usd_rx.sv
module usd_rx
   import uart_split_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             rxd,
   output logic             byte_valid,
   output logic [7:0]       byte_data
);

   if (SYNC < 1) begin : g_bad_sync
      $error("usd_rx: SYNC must be at least 1");
   end

   rx_state_e        st_q;
   logic             rx_s;
   logic [7:0]       shreg_q;
   logic [2:0]       bitn_q;
   logic [DIV_W-1:0] div_q, target;
   logic             restart, expire;

   // input synchroniser, one stage or a chain
   if (SYNC == 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b1;
         else        s_q <= rxd;
      end
      assign rx_s = s_q;
   end else begin : g_syncn
      logic [SYNC-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= '1;
         else        s_q <= {s_q[SYNC-2:0], rxd};
      end
      assign rx_s = s_q[SYNC-1];
   end

   assign restart   = (st_q == RX_IDLE) && !rx_s;
   assign target    = (st_q == RX_START) ? (div_q >> 1) : div_q;
   assign byte_data = shreg_q;

   usd_bit_timer #(.CNT_W(DIV_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .target  (target),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         shreg_q    <= '0;
         bitn_q     <= '0;
         div_q      <= DIV_W'(2);
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= (st_q == RX_STOP) && expire && rx_s;
         case (st_q)
            RX_IDLE: begin
               if (!rx_s) begin
                  div_q <= div;
                  st_q  <= RX_START;
               end
            end
            RX_START: begin
               if (expire) begin
                  // a pulse that is high again at mid-bit is noise
                  st_q   <= rx_s ? RX_IDLE : RX_DATA;
                  bitn_q <= '0;
               end
            end
            RX_DATA: begin
               if (expire) begin
                  shreg_q <= {rx_s, shreg_q[7:1]};
                  if (bitn_q == 3'd7) st_q <= RX_STOP;
                  else                bitn_q <= bitn_q + 1'b1;
               end
            end
            default: begin
               if (expire) begin
                  st_q <= RX_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/uart_split_div.sv
module uart_split_div
   import uart_split_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int DIV_W       = 16,
   parameter int DEPTH       = 32,
   parameter int SYNC        = 2,
   parameter int DEFAULT_DIV = 833,
   localparam int HI_W  = DIV_W - LO_W,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       reg_addr,
   input  logic             reg_wen,
   input  logic             reg_ren,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             txd,
   input  logic             rxd
);

   if (DIV_W <= LO_W) begin : g_bad_divw
      $error("uart_split_div: DIV_W must exceed the lower field width");
   end
   if (BUS_W < HI_W || BUS_W < 8) begin : g_bad_busw
      $error("uart_split_div: BUS_W too narrow for the register fields");
   end
   if (DEFAULT_DIV < 2 || DEFAULT_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("uart_split_div: DEFAULT_DIV out of range");
   end

   logic [HI_W-1:0]  div_hi_q;
   logic [LO_W-1:0]  div_lo_q;
   logic [DIV_W-1:0] div_raw, div_eff;
   logic             ovr_q;

   logic             wr_data, rd_data;
   logic             tx_empty, tx_full, tx_pop, tx_busy;
   logic [7:0]       tx_head;
   logic [LVL_W-1:0] tx_level;
   logic             rx_empty, rx_full, rx_valid;
   logic [7:0]       rx_head, rx_byte;
   logic [LVL_W-1:0] rx_level;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_data = reg_wen && (reg_addr == OFS_DATA);
   assign rd_data = reg_ren && (reg_addr == OFS_DATA);

   // divisor: upper part then lower six bits; below two is forced to two
   assign div_raw = {div_hi_q, div_lo_q};
   assign div_eff = (div_raw < DIV_W'(2)) ? DIV_W'(2) : div_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_hi_q <= HI_W'(DEFAULT_DIV >> LO_W);
         div_lo_q <= LO_W'(DEFAULT_DIV % (1 << LO_W));
         ovr_q    <= 1'b0;
      end else begin
         if (reg_wen && reg_addr == OFS_DHI) div_hi_q <= reg_wdata[HI_W-1:0];
         if (reg_wen && reg_addr == OFS_DLO) div_lo_q <= reg_wdata[LO_W-1:0];
         if (rx_valid && rx_full)            ovr_q    <= 1'b1;
      end
   end

   usd_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data),
      .wdata (reg_wdata[7:0]),
      .pop   (tx_pop),
      .rdata (tx_head),
      .empty (tx_empty),
      .full  (tx_full),
      .level (tx_level)
   );

   usd_tx #(.DIV_W(DIV_W)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .div        (div_eff),
      .fifo_empty (tx_empty),
      .fifo_data  (tx_head),
      .fifo_pop   (tx_pop),
      .txd        (txd),
      .busy       (tx_busy)
   );

   usd_rx #(.DIV_W(DIV_W), .SYNC(SYNC)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .div        (div_eff),
      .rxd        (rxd),
      .byte_valid (rx_valid),
      .byte_data  (rx_byte)
   );

   usd_fifo #(.WIDTH(8), .DEPTH(DEPTH)) i_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .wdata (rx_byte),
      .pop   (rd_data),
      .rdata (rx_head),
      .empty (rx_empty),
      .full  (rx_full),
      .level (rx_level)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_DATA: reg_rdata = rx_empty ? '0 : BUS_W'(rx_head);
         OFS_STAT: begin
            reg_rdata[ST_OVR] = ovr_q;
            reg_rdata[ST_RXE] = rx_empty;
            reg_rdata[ST_TXF] = tx_full;
         end
         OFS_DHI:  reg_rdata = BUS_W'(div_hi_q);
         OFS_DLO:  reg_rdata = BUS_W'(div_lo_q);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/uart_split_div_chk.sv
module uart_split_div_chk
   import uart_split_pkg::*;
#(
   parameter int BUS_W = 32,
   parameter int DEPTH = 32,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       reg_addr,
   input logic             reg_wen,
   input logic             reg_ren,
   input logic [BUS_W-1:0] reg_rdata,
   input logic             txd,
   input logic             tx_busy,
   input logic             tx_pop,
   input logic [LVL_W-1:0] tx_level,
   input logic [LVL_W-1:0] rx_level,
   input logic             ovr_q
);

   AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd) else $error("txd low while idle"); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)))
      else $error("queue level above depth"); // R5

   AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == OFS_DATA && tx_level == LVL_W'(DEPTH) && !tx_pop)
      |=> (tx_level == LVL_W'(DEPTH))) else $error("write into full queue"); // R7

   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> ovr_q) else $error("overrun flag cleared"); // R8

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ren && reg_addr == OFS_DATA && rx_level == '0) |-> (reg_rdata == '0))
      else $error("empty read not zero"); // R9

   AST_STATUS_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_STAT) |-> (reg_rdata[ST_RXE] == (rx_level == '0)))
      else $error("status empty bit wrong"); // R6

endmodule

bind uart_split_div uart_split_div_chk #(.BUS_W(BUS_W), .DEPTH(DEPTH)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wen   (reg_wen),
   .reg_ren   (reg_ren),
   .reg_rdata (reg_rdata),
   .txd       (txd),
   .tx_busy   (tx_busy),
   .tx_pop    (tx_pop),
   .tx_level  (tx_level),
   .rx_level  (rx_level),
   .ovr_q     (ovr_q)
);

// File: tb/test_uart_split_div.sv
module test_uart_split_div;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {hi, lo, byte}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h00_0C_A5, 24'h00_11_3C, 24'h01_06_81,
      24'h00_3F_00, 24'h00_09_FF, 24'h02_00_5A
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic        reg_wen = 1'b0;
   logic        reg_ren = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        txd, rxd;
   logic        loop_en = 1'b0;
   logic        drv_rxd = 1'b1;

   int total = 0;
   int bad = 0;
   int mon_div = 833;
   int mon_cnt = 0;
   logic [7:0] mon_bytes [64];
   logic       mon_ok [64];

   assign rxd = loop_en ? txd : drv_rxd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_split_div i_uart_split_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wen   (reg_wen),
      .reg_ren   (reg_ren),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .txd       (txd),
      .rxd       (rxd)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wen   = 1'b1;
      reg_ren   = 1'b0;
      @(negedge clk);
      reg_wen   = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wen  = 1'b0;
      reg_addr = a;
      reg_ren  = 1'b1;
      #1;
      d = reg_rdata;
      @(negedge clk);
      reg_ren  = 1'b0;
   endtask

   task automatic set_div(input int d);
      bus_write(4'h8, 32'(d >> 6));
      bus_write(4'hC, 32'(d % 64));
   endtask

   task automatic rx_send(input logic [7:0] b, input int d);
      @(negedge clk);
      drv_rxd = 1'b0;
      repeat (d) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         drv_rxd = b[i];
         repeat (d) @(negedge clk);
      end
      drv_rxd = 1'b1;
      repeat (d + 2) @(negedge clk);
   endtask

   // txd frame decoder sampling at mid-bit with the divisor current at the start bit
   initial begin : p_mon
      int d;
      logic [7:0] b;
      logic ok;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            d  = mon_div;
            ok = 1'b1;
            repeat (d / 2) @(negedge clk);
            if (txd !== 1'b0) ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
               repeat (d) @(negedge clk);
               b[i] = txd;
            end
            repeat (d) @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
            if (mon_cnt < 64) begin
               mon_bytes[mon_cnt] = b;
               mon_ok[mon_cnt]    = ok;
               mon_cnt++;
            end
         end
      end
   end

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      logic [31:0] r;
      int base;
      int d;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 txd", 32'(txd), 32'h1);
      bus_read(4'h4, r); chk("R1 status", r, 32'h10);
      bus_read(4'h8, r); chk("R1 div hi", r, 32'd13);
      bus_read(4'hC, r); chk("R1 div lo", r, 32'd1);

      // R9 read of an empty receive queue
      bus_read(4'h0, r); chk("R9 empty read", r, 32'h0);
      bus_read(4'h4, r); chk("R9 still empty", r, 32'h10);

      // table of divisor settings and bytes, txd looped to rxd
      loop_en = 1'b1;
      for (int v = 0; v < NVEC; v++) begin
         d = int'(VEC[v][23:16]) * 64 + int'(VEC[v][15:8]);
         bus_write(4'h8, 32'(VEC[v][23:16]));
         bus_write(4'hC, 32'(VEC[v][15:8]));
         bus_read(4'hC, r); chk("R3 lo readback", r, 32'(VEC[v][13:8]));
         mon_div = d;
         base = mon_cnt;
         bus_write(4'h0, {24'hFFFFFF, VEC[v][7:0]});
         repeat (11 * d + 20) @(negedge clk);
         chk("R3 frame count", 32'(mon_cnt - base), 32'd1);
         chk("R2 frame byte", {23'h0, mon_ok[base], mon_bytes[base]}, {23'h0, 1'b1, VEC[v][7:0]});
         bus_read(4'h0, r); chk("R4 loopback byte", r, {24'h0, VEC[v][7:0]});
      end
      loop_en = 1'b0;

      // R11 divisor change in mid-frame
      set_div(20);
      mon_div = 20;
      base = mon_cnt;
      bus_write(4'h0, 32'hC3);
      repeat (30) @(negedge clk);
      bus_write(4'hC, 32'd40);
      mon_div = 40;
      repeat (11 * 20) @(negedge clk);
      chk("R11 old timing kept", {23'h0, mon_ok[base], mon_bytes[base]}, {23'h0, 1'b1, 8'hC3});
      bus_write(4'h0, 32'h2D);
      repeat (11 * 40 + 20) @(negedge clk);
      chk("R11 new timing used", {23'h0, mon_ok[base+1], mon_bytes[base+1]}, {23'h0, 1'b1, 8'h2D});

      // R7 R5 burst of 34 writes into the transmit queue
      set_div(4);
      mon_div = 4;
      repeat (50) @(negedge clk);
      base = mon_cnt;
      for (int i = 0; i < 34; i++) begin
         @(negedge clk);
         reg_addr  = 4'h0;
         reg_wdata = 32'(i);
         reg_wen   = 1'b1;
      end
      bus_read(4'h4, r); chk("R6 R5 tx full bit", r & 32'h20, 32'h20);
      repeat (34 * 44 + 100) @(negedge clk);
      chk("R7 frames sent", 32'(mon_cnt - base), 32'd33);
      for (int i = 0; i < 33; i++) begin
         chk("R7 byte order", {23'h0, mon_ok[base+i], mon_bytes[base+i]}, {23'h0, 1'b1, 8'(i)});
      end
      bus_read(4'h4, r); chk("R6 tx drained", r, 32'h10);

      // R10 short low pulse on rxd
      set_div(16);
      @(negedge clk);
      drv_rxd = 1'b0;
      repeat (3) @(negedge clk);
      drv_rxd = 1'b1;
      repeat (100) @(negedge clk);
      bus_read(4'h4, r); chk("R10 glitch ignored", r, 32'h10);
      rx_send(8'h96, 16);
      repeat (20) @(negedge clk);
      bus_read(4'h0, r); chk("R10 frame after glitch", r, 32'h96);

      // R8 overrun with 33 frames
      set_div(8);
      for (int i = 0; i < 33; i++) begin
         rx_send(8'(8'h40 + i), 8);
      end
      repeat (30) @(negedge clk);
      bus_read(4'h4, r); chk("R8 overrun status", r, 32'h01);
      for (int i = 0; i < 32; i++) begin
         bus_read(4'h0, r); chk("R5 R4 kept byte", r, 32'(8'h40 + i));
      end
      bus_read(4'h4, r); chk("R8 overrun sticky", r, 32'h11);
      bus_read(4'h0, r); chk("R9 empty after drain", r, 32'h0);
      bus_read(4'h4, r); chk("R9 pointers held", r, 32'h11);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule